// File: doc/BRIEF.md
# Indexed Configuration Port with Bus-Ready Watchdog

This block is a small bank of eight-bit configuration registers that sits behind two I/O addresses. Software first writes a register number to the index port. Its very next bus access may then read or write the selected register through the data port. Any other access order is discarded. This guards the registers against stray writes. Three registers are implemented: a clock and status register, a command delay register and a wait-state register. Their fields drive static outputs towards the bus engines.

The block also watches the local bus. While a local-bus cycle is pending without a ready indication, a counter advances once per clock. When it reaches 128 clocks, a sticky timeout flag is set in the clock and status register. If the enable bit in that register is set, the block also emits a one-clock NMI pulse. A rising edge on the software reset bit produces a fixed-length fast CPU reset pulse.

Top module: `cfg_port_bank`

## Requirements
- R1: A write strobe to the index address (default 22h) stores the eight-bit register number. A read of the index address returns FFh.
- R2: A read or write on the data address (default 23h) takes effect only when the previous bus access, at any address, was a write to the index address. Idle cycles in between are allowed. Otherwise the write changes nothing and the read returns FFh.
- R3: Every data-address access uses up the unlock. A further data access needs a fresh index write first. Any access to an unrelated address also cancels the unlock.
- R4: Register numbers other than 60h, 61h and 62h read as FFh through the data port. Writes to them change no register and no output.
- R5: Register 60h has the following bit layout:
  - bits 7-6 read as 00;
  - bit 4 is the clock source select and drives cpu_clk_sel, resetting to 0;
  - bit 2 is the timeout NMI enable, resetting to 0;
  - bits 3 and 1 read as 0.
- R6: A write of 1 to bit 5 of register 60h, while that bit holds 0, drives fast_rst high for exactly 16 clocks, starting the cycle after the write. Writing 1 while the bit already holds 1 gives no pulse. Bit 5 reads back as written.
- R7: After 128 consecutive clocks with lb_pending high, bit 0 of register 60h becomes 1. It stays 1 until software writes 0 to it. Writing 1 to it has no effect.
- R8: On the clock edge where the timeout is reached, nmi_pulse goes high for exactly one cycle if bit 2 of register 60h is 1, and stays low if it is 0. One pending period gives at most one timeout.
- R9: Register 61h resets to 45h and has this layout:
  - bit 7 drives addr_hold_ext;
  - bit 6 always reads 1;
  - bits 5-4 drive mem16_dly;
  - bits 3-2 drive mem8_dly;
  - bits 1-0 drive io_cmd_dly.
- R10: Register 62h resets with bits 5-0 = 3Ch and has this layout:
  - bits 5-4 drive ws16;
  - bits 3-2 drive ws8;
  - bits 1-0 drive bclk_sel;
  - bit 7 reads the fpu_present input and bit 6 reads the fpu_ready input; writes to bits 7-6 are ignored.
- R11: If lb_pending drops low for even one clock, the timeout count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | I/O address of the current access |
| io_wr | input | 1 | One-cycle write strobe |
| io_rd | input | 1 | One-cycle read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid during the read strobe cycle |
| lb_pending | input | 1 | Local-bus cycle waiting for ready |
| fpu_present | input | 1 | Coprocessor fitted |
| fpu_ready | input | 1 | Coprocessor ready |
| cpu_clk_sel | output | 1 | Processor clock source select |
| addr_hold_ext | output | 1 | Extra address hold time enable |
| io_cmd_dly | output | 2 | I/O command delay |
| mem8_dly | output | 2 | 8-bit memory access delay |
| mem16_dly | output | 2 | 16-bit memory access delay |
| ws8 | output | 2 | 8-bit cycle wait-state code |
| ws16 | output | 2 | 16-bit cycle wait-state code |
| bclk_sel | output | 2 | Bus clock select code |
| nmi_pulse | output | 1 | One-cycle NMI request on timeout |
| fast_rst | output | 1 | Fast CPU reset pulse |

## Verification
The hardest state to reach is a timeout that lands exactly on the 128th pending clock. The bench must also show that a one-clock gap in lb_pending restarts the count. The stimulus holds lb_pending high from a falling edge and samples nmi_pulse after 127, 128 and 129 rising edges. A second run holds lb_pending for 100 clocks, drops it for one clock, then holds it for 127 clocks and expects no pulse. The unlock rule is driven by placing data accesses right after index writes. It is also driven by placing them after data accesses and after accesses to unrelated addresses. Each write is then read back through a properly unlocked read.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

    localparam logic [7:0] IDX_CLK  = 8'h60;
    localparam logic [7:0] IDX_CDLY = 8'h61;
    localparam logic [7:0] IDX_WS   = 8'h62;

    localparam logic [7:0] CDLY_RST = 8'h45;
    localparam logic [5:0] WS_RST   = 6'h3C;
    localparam logic [7:0] RD_NONE  = 8'hFF;

    typedef struct packed {
        logic rst_bit;
        logic clk_sel;
        logic nmi_en;
        logic to_flag;
    } clk_reg_t;

endpackage

// File: rtl/cfg_access.sv
module cfg_access #(
    parameter int unsigned ADDR_W = 16,
    parameter logic [ADDR_W-1:0] INDEX_ADDR = 'h22,
    parameter logic [ADDR_W-1:0] DATA_ADDR  = 'h23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        idx_o,
    output logic              unlock_o,
    output logic              data_wr_o,
    output logic              data_rd_o
);

    typedef struct packed {
        logic       unlock;
        logic [7:0] idx;
    } acc_t;

    acc_t s_d, s_q;
    logic idx_wr, dsel;

    always_comb begin
        s_d       = s_q;
        idx_wr    = io_wr && (io_addr == INDEX_ADDR);
        dsel      = (io_addr == DATA_ADDR);
        data_wr_o = io_wr && dsel && s_q.unlock;
        data_rd_o = io_rd && dsel && s_q.unlock;
        if (io_wr || io_rd) begin
            s_d.unlock = idx_wr;
        end
        if (idx_wr) begin
            s_d.idx = io_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign idx_o    = s_q.idx;
    assign unlock_o = s_q.unlock;

    AST_DATA_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
        ((io_wr || io_rd) && io_addr == DATA_ADDR) |=> !unlock_o) else $error("unlock kept"); // R3
    AST_INDEX_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == INDEX_ADDR) |=> (unlock_o && idx_o == $past(io_wdata))) else $error("no unlock"); // R1

endmodule

// File: rtl/cfg_ready_wdog.sv
module cfg_ready_wdog #(
    parameter int unsigned LIMIT = 128,
    localparam int unsigned CNT_W = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pending_i,
    output logic expire_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } wd_t;

    wd_t w_d, w_q;

    always_comb begin
        w_d      = w_q;
        expire_o = pending_i && (w_q.cnt == CNT_W'(LIMIT - 1));
        if (!pending_i) begin
            w_d.cnt = '0;
        end else if (w_q.cnt != CNT_W'(LIMIT)) begin
            w_d.cnt = w_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        w_q.cnt <= CNT_W'(LIMIT)) else $error("count overrun"); // R7
    AST_EXPIRE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> !expire_o) else $error("double expire"); // R8
    AST_GAP_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        !pending_i |=> !expire_o) else $error("expire after gap"); // R11

endmodule

// File: rtl/cfg_rst_pulse.sv
module cfg_rst_pulse #(
    parameter int unsigned PULSE = 16,
    localparam int unsigned CNT_W = $clog2(PULSE + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic pulse_o
);

    typedef struct packed {
        logic [CNT_W-1:0] left;
    } rp_t;

    rp_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (trig_i) begin
            p_d.left = CNT_W'(PULSE);
        end else if (p_q.left != '0) begin
            p_d.left = p_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign pulse_o = (p_q.left != '0);

    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |-> $past(trig_i)) else $error("pulse without trigger"); // R6

endmodule

// File: rtl/cfg_port_bank.sv
module cfg_port_bank
    import cfg_port_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter logic [ADDR_W-1:0] INDEX_ADDR = 'h22,
    parameter logic [ADDR_W-1:0] DATA_ADDR  = 'h23,
    parameter int unsigned TIMEOUT_CLKS = 128,
    parameter int unsigned RST_CLKS = 16,
    parameter logic [1:0] RELEASE = 2'b00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic              lb_pending,
    input  logic              fpu_present,
    input  logic              fpu_ready,
    output logic              cpu_clk_sel,
    output logic              addr_hold_ext,
    output logic [1:0]        io_cmd_dly,
    output logic [1:0]        mem8_dly,
    output logic [1:0]        mem16_dly,
    output logic [1:0]        ws8,
    output logic [1:0]        ws16,
    output logic [1:0]        bclk_sel,
    output logic              nmi_pulse,
    output logic              fast_rst
);

    typedef struct packed {
        clk_reg_t   c;
        logic [7:0] cdly;
        logic [5:0] ws;
        logic       nmi;
    } regs_t;

    regs_t r_d, r_q;
    logic [7:0] idx;
    logic unlocked, data_wr, data_rd, expire, fast_trig;

    cfg_access #(
        .ADDR_W(ADDR_W), .INDEX_ADDR(INDEX_ADDR), .DATA_ADDR(DATA_ADDR)
    ) u_acc (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .idx_o(idx), .unlock_o(unlocked),
        .data_wr_o(data_wr), .data_rd_o(data_rd)
    );

    cfg_ready_wdog #(.LIMIT(TIMEOUT_CLKS)) u_wdog (
        .clk(clk), .rst_n(rst_n), .pending_i(lb_pending), .expire_o(expire)
    );

    cfg_rst_pulse #(.PULSE(RST_CLKS)) u_rstp (
        .clk(clk), .rst_n(rst_n), .trig_i(fast_trig), .pulse_o(fast_rst)
    );

    always_comb begin
        r_d       = r_q;
        r_d.nmi   = 1'b0;
        fast_trig = 1'b0;
        if (data_wr) begin
            case (idx)
                IDX_CLK: begin
                    fast_trig     = io_wdata[5] && !r_q.c.rst_bit;
                    r_d.c.rst_bit = io_wdata[5];
                    r_d.c.clk_sel = io_wdata[4];
                    r_d.c.nmi_en  = io_wdata[2];
                    if (!io_wdata[0]) begin
                        r_d.c.to_flag = 1'b0;
                    end
                end
                IDX_CDLY: r_d.cdly = {io_wdata[7], 1'b1, io_wdata[5:0]};
                IDX_WS:   r_d.ws   = io_wdata[5:0];
                default:  ;
            endcase
        end
        if (expire) begin
            r_d.c.to_flag = 1'b1;
            r_d.nmi       = r_q.c.nmi_en;
        end
    end

    always_comb begin
        io_rdata = RD_NONE;
        if (data_rd) begin
            case (idx)
                IDX_CLK:  io_rdata = {RELEASE, r_q.c.rst_bit, r_q.c.clk_sel,
                                      1'b0, r_q.c.nmi_en, 1'b0, r_q.c.to_flag};
                IDX_CDLY: io_rdata = r_q.cdly;
                IDX_WS:   io_rdata = {fpu_present, fpu_ready, r_q.ws};
                default:  io_rdata = RD_NONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.cdly <= CDLY_RST;
            r_q.ws   <= WS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign cpu_clk_sel   = r_q.c.clk_sel;
    assign addr_hold_ext = r_q.cdly[7];
    assign mem16_dly     = r_q.cdly[5:4];
    assign mem8_dly      = r_q.cdly[3:2];
    assign io_cmd_dly    = r_q.cdly[1:0];
    assign ws16          = r_q.ws[5:4];
    assign ws8           = r_q.ws[3:2];
    assign bclk_sel      = r_q.ws[1:0];
    assign nmi_pulse     = r_q.nmi;

    AST_LOCKED_WR_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == DATA_ADDR && !unlocked && !expire)
        |=> ($stable(r_q.cdly) && $stable(r_q.ws) && $stable(r_q.c))) else $error("locked write"); // R2
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.c.to_flag && !data_wr) |=> r_q.c.to_flag) else $error("flag lost"); // R7
    AST_NMI_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_pulse) |-> $past(r_q.c.nmi_en)) else $error("nmi while disabled"); // R8
    AST_CDLY_BIT6: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cdly[6]) else $error("bit6 low"); // R9

endmodule

// File: tb/cfg_port_bank_tb.sv
module cfg_port_bank_tb;

    localparam logic [15:0] A_IDX = 16'h0022;
    localparam logic [15:0] A_DAT = 16'h0023;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0] io_wdata = '0, io_rdata;
    logic lb_pending = 1'b0, fpu_present = 1'b1, fpu_ready = 1'b0;
    logic cpu_clk_sel, addr_hold_ext, nmi_pulse, fast_rst;
    logic [1:0] io_cmd_dly, mem8_dly, mem16_dly, ws8, ws16, bclk_sel;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cfg_port_bank u_dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .lb_pending(lb_pending),
        .fpu_present(fpu_present), .fpu_ready(fpu_ready), .cpu_clk_sel(cpu_clk_sel),
        .addr_hold_ext(addr_hold_ext), .io_cmd_dly(io_cmd_dly), .mem8_dly(mem8_dly),
        .mem16_dly(mem16_dly), .ws8(ws8), .ws16(ws16), .bclk_sel(bclk_sel),
        .nmi_pulse(nmi_pulse), .fast_rst(fast_rst)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #4 d = io_rdata;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic reg_wr(input logic [7:0] idx, input logic [7:0] d);
        io_write(A_IDX, idx);
        io_write(A_DAT, d);
    endtask

    task automatic reg_rd(input logic [7:0] idx, output logic [7:0] d);
        io_write(A_IDX, idx);
        io_read(A_DAT, d);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R9 reset io_cmd_dly", io_cmd_dly, 1);
        check("R9 reset mem8_dly", mem8_dly, 1);
        check("R9 reset mem16_dly", mem16_dly, 0);
        check("R10 reset ws16", ws16, 3);
        check("R10 reset ws8", ws8, 3);
        check("R10 reset bclk_sel", bclk_sel, 0);
        check("R5 reset cpu_clk_sel", cpu_clk_sel, 0);
        check("R6 reset fast_rst", fast_rst, 0);
        check("R8 reset nmi", nmi_pulse, 0);
        reg_rd(8'h60, v); check("R5 reset reg60", v, 8'h00);
        reg_rd(8'h61, v); check("R9 reset reg61", v, 8'h45);
        reg_rd(8'h62, v); check("R10 reset reg62", v, 8'hBC);
    endtask

    task automatic t_lock();
        logic [7:0] v;
        io_write(A_DAT, 8'h00);
        reg_rd(8'h61, v); check("R2 write without unlock dropped", v, 8'h45);
        io_read(A_DAT, v); check("R2 read without unlock", v, 8'hFF);
        io_read(A_IDX, v); check("R1 index port reads FF", v, 8'hFF);
    endtask

    task automatic t_consume();
        logic [7:0] v;
        reg_wr(8'h61, 8'h8A);
        check("R9 addr_hold_ext", addr_hold_ext, 1);
        check("R9 io_cmd_dly", io_cmd_dly, 2);
        check("R9 mem8_dly", mem8_dly, 2);
        check("R9 mem16_dly", mem16_dly, 0);
        io_write(A_DAT, 8'h00);
        reg_rd(8'h61, v); check("R3 second data write dropped, bit6 reads 1", v, 8'hCA);
        io_read(A_DAT, v); check("R3 second data read locked", v, 8'hFF);
        io_write(A_IDX, 8'h61);
        io_write(16'h0080, 8'h11);
        io_write(A_DAT, 8'h00);
        reg_rd(8'h61, v); check("R3 foreign access cancels unlock", v, 8'hCA);
    endtask

    task automatic t_unimpl();
        logic [7:0] v;
        reg_wr(8'h63, 8'h00);
        reg_rd(8'h63, v); check("R4 unimplemented reads FF", v, 8'hFF);
        reg_rd(8'h62, v); check("R4 reg62 untouched", v, 8'hBC);
        check("R4 outputs untouched", {ws16, ws8, bclk_sel}, 6'h3C);
    endtask

    task automatic t_r60();
        logic [7:0] v;
        reg_wr(8'h60, 8'hDE);
        reg_rd(8'h60, v); check("R5 reg60 layout", v, 8'h14);
        check("R5 cpu_clk_sel", cpu_clk_sel, 1);
        check("R6 no pulse with bit5 0", fast_rst, 0);
    endtask

    task automatic count_rst(input string req, input int exp);
        int n = 0;
        for (int i = 0; i < 20; i++) begin
            if (fast_rst) n++;
            @(negedge clk);
        end
        check(req, n, exp);
    endtask

    task automatic t_fastrst();
        logic [7:0] v;
        io_write(A_IDX, 8'h60);
        io_write(A_DAT, 8'h34);
        count_rst("R6 rising bit5 pulse length", 16);
        reg_wr(8'h60, 8'h34);
        count_rst("R6 bit5 already 1 no pulse", 0);
        reg_wr(8'h60, 8'h14);
        reg_wr(8'h60, 8'h34);
        count_rst("R6 second rising edge", 16);
        reg_rd(8'h60, v); check("R6 bit5 reads back", v, 8'h34);
    endtask

    task automatic t_wdog();
        logic [7:0] v;
        int extra = 0;
        @(negedge clk); lb_pending = 1'b1;
        repeat (127) @(negedge clk);
        check("R8 no nmi before 128", nmi_pulse, 0);
        @(negedge clk);
        check("R8 nmi at 128", nmi_pulse, 1);
        @(negedge clk);
        check("R8 nmi one cycle", nmi_pulse, 0);
        for (int i = 0; i < 10; i++) begin
            if (nmi_pulse) extra++;
            @(negedge clk);
        end
        check("R8 one timeout per pending", extra, 0);
        lb_pending = 1'b0;
        reg_rd(8'h60, v); check("R7 flag set", v, 8'h35);
        reg_wr(8'h60, 8'h35);
        reg_rd(8'h60, v); check("R7 write 1 keeps flag", v, 8'h35);
        reg_wr(8'h60, 8'h34);
        reg_rd(8'h60, v); check("R7 write 0 clears flag", v, 8'h34);
    endtask

    task automatic t_restart();
        logic [7:0] v;
        int seen = 0;
        @(negedge clk); lb_pending = 1'b1;
        repeat (100) @(negedge clk);
        lb_pending = 1'b0;
        @(negedge clk); lb_pending = 1'b1;
        for (int i = 0; i < 127; i++) begin
            @(negedge clk);
            if (nmi_pulse) seen++;
        end
        check("R11 gap restarts count", seen, 0);
        @(negedge clk);
        check("R11 timeout after fresh 128", nmi_pulse, 1);
        lb_pending = 1'b0;
        reg_wr(8'h60, 8'h30);
        seen = 0;
        @(negedge clk); lb_pending = 1'b1;
        for (int i = 0; i < 135; i++) begin
            @(negedge clk);
            if (nmi_pulse) seen++;
        end
        lb_pending = 1'b0;
        check("R8 no nmi when disabled", seen, 0);
        reg_rd(8'h60, v); check("R7 flag set with nmi disabled", v, 8'h31);
    endtask

    task automatic t_r62();
        logic [7:0] v;
        reg_wr(8'h62, 8'hC1);
        check("R10 bclk_sel", bclk_sel, 1);
        check("R10 ws8 ws16", {ws16, ws8}, 0);
        reg_rd(8'h62, v); check("R10 status bits from inputs", v, 8'h81);
        fpu_ready = 1'b1; fpu_present = 1'b0;
        reg_rd(8'h62, v); check("R10 status follows inputs", v, 8'h41);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_lock();
        t_consume();
        t_unimpl();
        t_r60();
        t_fastrst();
        t_wdog();
        t_restart();
        t_r62();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule